// File: doc/BRIEF.md
# Flash Byte/Word Data Pin Front End

This block sits between the storage core of a parallel NOR flash model and its sixteen data pins. It takes active-low chip-enable and output-enable, a width-select pin, the word address and the word the core has read. From these it produces a per-pin output value and a per-pin output enable for a bidirectional pad ring. The surrounding pad logic turns each pin whose enable is low into a high-impedance pin.

In word configuration, all sixteen pins carry the read word. In byte configuration, only the lower eight pins are driven. Pins 8 to 14 float, and the top pin becomes an address input. That input acts as the lowest address bit and picks which half of the internal word appears on the lower pins. The block also exports the full byte address, which is the word address with that bit appended, for a storage array that wants it.

The width chosen when a read access begins holds for the whole access. A change on the width-select pin takes effect only when the next access starts. Pin outputs are registered: inputs sampled on one rising edge show on the pins right after that edge. The byte address is combinational.

Top module: `fbi_dq_frontend`

## Requirements
- R1: After reset, `dq_oe` and `dq_out` are all zero.
- R2: When `ce_n` was high at the last rising edge, every bit of `dq_oe` is 0 after that edge, whatever `oe_n` is. Whenever `dq_oe` is all zero, `dq_out` is all zero too.
- R3: When `oe_n` was high at the last rising edge, every bit of `dq_oe` is 0 after that edge.
- R4: A read access is active while `ce_n` and `oe_n` are both low. In word width (`byte_n` = 1), an access sampled on a rising edge sets all 16 bits of `dq_oe` to 1 and sets `dq_out` to `rd_word` after that edge.
- R5: In byte width (`byte_n` = 0), an access sets only `dq_oe[7:0]` to 1. Bits 14:8 stay 0, and bit 15 stays 0 because that pin is an input.
- R6: In byte width, `dq_top_in` = 0 places `rd_word[7:0]` on `dq_out[7:0]`, and `dq_top_in` = 1 places `rd_word[15:8]` there. `dq_out[15:8]` is 0.
- R7: `byte_addr` equals {`addr`, lsb}. In byte width, lsb is `dq_top_in`. In word width, lsb is 0. The path is combinational.
- R8: The width is captured on the first edge of an access and held until the access ends. A change on `byte_n` during an access has no effect on `dq_oe`, `dq_out` or `byte_addr` until a new access begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_n | input | 1 | Width select: 1 selects word, 0 selects byte |
| addr | input | ADDR_W | Word address |
| rd_word | input | DATA_W | Word read from the storage core |
| dq_top_in | input | 1 | Input value sampled from the top data pin |
| dq_out | output | DATA_W | Value for each data pin |
| dq_oe | output | DATA_W | Output enable for each data pin |
| byte_addr | output | ADDR_W+1 | Word address with the byte-select bit appended |

## Verification
The bench flips `byte_n` in the middle of an access in both directions. A design that follows the pin directly would widen or narrow the bus during a read and change the address bit mid-access. Within one byte-width access it toggles the top pin to catch a design whose lane select is inverted, or one that freezes the select at access start. It also raises `dq_top_in` during word reads, where a design that let the pin reach the address would produce odd byte addresses. It raises `ce_n` and `oe_n` one at a time with the other held low, which catches a design that gates the enables on only one of them.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
   typedef enum logic {
      WIDTH_BYTE = 1'b0,
      WIDTH_WORD = 1'b1
   } width_e;
endpackage

// File: rtl/fbi_access_track.sv
// Tracks read accesses and holds the width mode captured at access start.
module fbi_access_track
   import fbi_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ce_n,
   input  logic   oe_n,
   input  logic   byte_n,
   output logic   access,
   output width_e cur_width
);
   logic   acc_q;
   width_e mode_q;
   width_e pin_width;
   logic   start;

   assign access    = !ce_n && !oe_n;
   assign start     = access && !acc_q;
   assign pin_width = byte_n ? WIDTH_WORD : WIDTH_BYTE;

   // Mid-access, the latched mode wins; otherwise the live pin is used.
   always_comb begin
      if (access && !start) cur_width = mode_q;
      else                  cur_width = pin_width;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= 1'b0;
         mode_q <= WIDTH_WORD;
      end else begin
         acc_q <= access;
         if (start) mode_q <= pin_width;
      end
   end
endmodule

// File: rtl/fbi_lane_sel.sv
// Routes internal word bits onto pin lanes for the current width.
module fbi_lane_sel
   import fbi_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  width_e            width,
   input  logic              a_lsb,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] lane_data
);
   localparam int HALF = DATA_W / 2;

   for (genvar i = 0; i < HALF; i++) begin : g_lane
      always_comb begin
         if (width == WIDTH_WORD) begin
            lane_data[i]      = rd_word[i];
            lane_data[i+HALF] = rd_word[i+HALF];
         end else begin
            lane_data[i]      = a_lsb ? rd_word[i+HALF] : rd_word[i];
            lane_data[i+HALF] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/fbi_pin_ctl.sv
// Per-pin drive enable from access state and width.
module fbi_pin_ctl
   import fbi_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              access,
   input  width_e            width,
   output logic [DATA_W-1:0] pin_en
);
   localparam int HALF = DATA_W / 2;

   for (genvar i = 0; i < DATA_W; i++) begin : g_pin
      if (i < HALF) begin : g_low
         assign pin_en[i] = access;
      end else begin : g_high
         assign pin_en[i] = access && (width == WIDTH_WORD);
      end
   end
endmodule

// File: rtl/fbi_dq_frontend.sv
// Data-pin front end: byte/word width, lane select, per-pin enables.
module fbi_dq_frontend
   import fbi_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              byte_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] rd_word,
   input  logic              dq_top_in,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe,
   output logic [ADDR_W:0]   byte_addr
);
   localparam int HALF = DATA_W / 2;

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("fbi_dq_frontend: DATA_W must be even and at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("fbi_dq_frontend: ADDR_W must be at least 1");
   end

   logic              access;
   width_e            cur_width;
   logic              a_lsb;
   logic [DATA_W-1:0] lane_data;
   logic [DATA_W-1:0] pin_en;

   fbi_access_track u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .byte_n    (byte_n),
      .access    (access),
      .cur_width (cur_width)
   );

   assign a_lsb     = (cur_width == WIDTH_BYTE) ? dq_top_in : 1'b0;
   assign byte_addr = {addr, a_lsb};

   fbi_lane_sel #(.DATA_W(DATA_W)) u_lane (
      .width     (cur_width),
      .a_lsb     (a_lsb),
      .rd_word   (rd_word),
      .lane_data (lane_data)
   );

   fbi_pin_ctl #(.DATA_W(DATA_W)) u_pin (
      .access (access),
      .width  (cur_width),
      .pin_en (pin_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_oe  <= '0;
         dq_out <= '0;
      end else begin
         dq_oe  <= pin_en;
         dq_out <= access ? lane_data : '0;
      end
   end

   // Unused in the default build; keeps HALF referenced for derived widths.
   logic [HALF-1:0] half_tie;
   assign half_tie = '0;
   logic unused_ok;
   assign unused_ok = &{1'b0, half_tie};
endmodule

// File: rtl/fbi_dq_checker.sv
module fbi_dq_checker #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              byte_n,
   input logic [ADDR_W-1:0] addr,
   input logic              dq_top_in,
   input logic [DATA_W-1:0] dq_out,
   input logic [DATA_W-1:0] dq_oe,
   input logic [ADDR_W:0]   byte_addr
);
   localparam int HALF = DATA_W / 2;

   logic acc;
   logic armed;
   assign acc = !ce_n && !oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_n) |-> dq_oe == '0); // R2
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe == '0) |-> dq_out == '0); // R2
   AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_n) |-> dq_oe == '0); // R3
   AST_UPPER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe[DATA_W-1] |-> dq_oe[DATA_W-2:HALF] == '0); // R5
   AST_BYTE_ADDR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !byte_n) |-> byte_addr == {addr, dq_top_in}); // R7
   AST_BYTE_ADDR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && byte_n) |-> byte_addr == {addr, 1'b0}); // R7
   AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && acc && $past(acc)) |=> $stable(dq_oe)); // R8
endmodule

bind fbi_dq_frontend fbi_dq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .oe_n      (oe_n),
   .byte_n    (byte_n),
   .addr      (addr),
   .dq_top_in (dq_top_in),
   .dq_out    (dq_out),
   .dq_oe     (dq_oe),
   .byte_addr (byte_addr)
);

// File: tb/sim_fbi_dq_frontend.sv
module sim_fbi_dq_frontend;
   localparam int DW = 16;
   localparam int AW = 19;

   typedef struct {
      int          due;
      logic [15:0] oe;
      logic [15:0] dat;
      string       tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, byte_n = 1'b1, dq_top_in = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] rd_word = '0;
   logic [DW-1:0] dq_out, dq_oe;
   logic [AW:0]   byte_addr;

   int    n_chk = 0, n_bad = 0, cyc = 0;
   item_t sb[$];
   logic  m_acc = 1'b0, m_word = 1'b1;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fbi_dq_frontend #(.DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .byte_n(byte_n),
      .addr(addr), .rd_word(rd_word), .dq_top_in(dq_top_in),
      .dq_out(dq_out), .dq_oe(dq_oe), .byte_addr(byte_addr));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: applies one vector at a falling edge, predicts the outputs.
   task automatic drive(logic ce, logic oe, logic bn, logic top,
                        logic [AW-1:0] a, logic [DW-1:0] rd, string tag);
      logic acc, start, word;
      item_t it;
      @(negedge clk);
      ce_n = ce; oe_n = oe; byte_n = bn; dq_top_in = top; addr = a; rd_word = rd;
      acc   = !ce && !oe;
      start = acc && !m_acc;
      word  = (acc && !start) ? m_word : bn;
      if (start) m_word = bn;
      m_acc = acc;
      it.due = cyc + 1;
      it.tag = tag;
      it.oe  = !acc ? 16'h0000 : (word ? 16'hFFFF : 16'h00FF);
      it.dat = !acc ? 16'h0000 : (word ? rd : {8'h00, top ? rd[15:8] : rd[7:0]});
      sb.push_back(it);
      #1;
      check({tag, " R7 byte_addr"}, 32'(byte_addr), 32'({a, word ? 1'b0 : top}));
   endtask

   // Monitor: pops expected results after the edge they belong to.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " dq_oe"}, 32'(dq_oe), 32'(it.oe));
            check({it.tag, " dq_out"}, 32'(dq_out), 32'(it.dat));
         end
      end
   end

   initial begin
      #(5 * 5000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset dq_oe", 32'(dq_oe), 32'h0);
      check("R1 reset dq_out", 32'(dq_out), 32'h0);
      rst_n = 1'b1;
      // R2 / R3: one enable high, other low
      drive(1, 0, 1, 0, 19'h00010, 16'hA55A, "R2 standby oe low");
      drive(1, 1, 0, 1, 19'h00011, 16'h1234, "R2 standby both high");
      drive(0, 1, 1, 0, 19'h00012, 16'hBEEF, "R3 output disabled");
      // R4 word reads, top pin high must not reach address
      drive(0, 0, 1, 0, 19'h00020, 16'hC3A1, "R4 word read");
      drive(0, 0, 1, 1, 19'h7FFFF, 16'h0F0F, "R4 word read top high");
      drive(0, 0, 1, 0, 19'h00000, 16'hFFFF, "R4 word read ones");
      // R8 byte_n dropped mid word access: stays word
      drive(0, 0, 0, 1, 19'h00021, 16'h8001, "R8 word held");
      drive(0, 0, 0, 0, 19'h00022, 16'h7E81, "R8 word held");
      drive(1, 0, 0, 0, 19'h00023, 16'h1111, "R2 access end");
      // R5/R6 byte access, lanes toggled inside one access
      drive(0, 0, 0, 0, 19'h00030, 16'hAB12, "R6 byte low half");
      drive(0, 0, 0, 1, 19'h00030, 16'hAB12, "R6 byte high half");
      drive(0, 0, 0, 1, 19'h40001, 16'h00FF, "R5 byte upper pins");
      // R8 byte_n raised mid byte access: stays byte
      drive(0, 0, 1, 1, 19'h00031, 16'h9C3D, "R8 byte held");
      drive(0, 0, 1, 0, 19'h00032, 16'h9C3D, "R8 byte held");
      drive(0, 1, 1, 0, 19'h00033, 16'h5555, "R3 access end");
      // R8 new access picks up the new width
      drive(0, 0, 1, 1, 19'h00034, 16'h6A6A, "R8 new word access");
      drive(0, 1, 0, 1, 19'h00035, 16'h6A6A, "R3 access end");
      drive(0, 0, 0, 1, 19'h00036, 16'h6A95, "R8 new byte access");
      drive(1, 1, 1, 0, 19'h00000, 16'h0000, "R2 idle");
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule